// File: doc/BRIEF.md
# Restricted-Format Serial Port with Receive Queue

This block is an asynchronous serial transmitter and receiver for one additional serial channel. Software reaches it through four byte-wide I/O registers with an address, a read strobe and a write strobe. A divisor register sets the line rate. A baud tick pulses once every `divisor + 1` clocks, and every bit lasts sixteen ticks.

Two character formats exist. The first has eight data bits and no parity. The second has seven data bits followed by one parity bit, and the parity sense can be even or odd. Either way a frame has ten bit times: a low start bit, eight payload bits sent least significant first, and a high stop bit. The line idles high.

The receiver confirms a start bit at its midpoint and then samples each later bit at mid-bit. It keeps characters in an eight-entry queue that is always on. Each entry stores its own framing and parity error flags. A single interrupt output combines two sources, each with its own enable: receive data present, and transmit holding register empty.

Top module: `fmt_uart`

## Requirements
- R1: After reset the line output `txd` is high, `irq` is low, `rdData` is 0x00, and the status register reads 0x22.
- R2: Register map. Address 0 reads the received character and writes the transmit holding register. Address 1 is status, read only. Address 2 is control: bit0 selects seven-bit parity mode, bit1 selects odd parity, bit2 enables the receive interrupt, bit3 enables the transmit interrupt. Address 3 holds the divisor. Control and divisor read back what was written. Read data appears on `rdData` one clock after the read strobe.
- R3: Every bit on `txd` after the start bit lasts exactly 16*(divisor+1) clocks.
- R4: In eight-bit mode a written byte goes out as a low start bit, data bits 0 to 7, and a high stop bit. A correctly framed byte on `rxd` is queued unchanged.
- R5: In parity mode the transmitter sends data bits 0 to 6 and then a parity bit, and ignores data bit 7. The parity bit makes the count of ones among the eight payload bits even (even sense) or odd (odd sense). A received character is returned with bit 7 cleared.
- R6: A received parity mismatch in parity mode sets status bit3 while that character is at the head of the queue.
- R7: A stop bit sampled low sets status bit2 while that character is at the head of the queue. The receiver then waits for the line to go high before it looks for the next start bit.
- R8: The receive queue holds 8 characters in arrival order. Status bit0 shows that the queue is not empty. Reading address 0 removes the head. Reading address 0 while the queue is empty returns 0x00 and changes no state.
- R9: A character that arrives while the queue is full is dropped and sets the sticky overrun flag, status bit4. Reading the status register clears that flag.
- R10: A low pulse on `rxd` shorter than half a bit time produces no character.
- R11: Status bit1 shows that the holding register is empty and status bit5 shows that the transmitter is idle. A write to address 0 while the holding register is full and the transmitter is busy is dropped.
- R12: `irq` is high while (receive interrupt enabled and queue not empty) or (transmit interrupt enabled and holding register empty), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| rdEn | input | 1 | Read strobe, one clock per access |
| wrEn | input | 1 | Write strobe, one clock per access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a full queue into overrun. A design that overwrote a stored entry, or failed to keep the flag set until a status read, would return the wrong eight characters or a wrong status value. It injects frames with a bad parity bit and with a low stop bit. A receiver that mixed up the parity sense, or restarted on a stop bit held low, would flag the wrong character or queue a spurious extra byte. It writes three bytes in quick succession. A holding register that accepted the third byte would send it, and a holding register that lost the second byte would drop it. It also feeds a glitch that is too short to be a start bit, and a receiver without mid-bit confirmation would queue a garbage byte.

// File: rtl/fmt_uart_pkg.sv
package fmt_uart_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic popRx;
    logic loadTx;
    logic clrOvr;
  } ctlStrobe_t;

  typedef struct packed {
    logic parityMode;
    logic oddSense;
  } frameCfg_t;

  typedef struct packed {
    logic rxAvail;
    logic holdEmpty;
    logic headFerr;
    logic headPerr;
    logic overrun;
    logic txIdle;
  } lineStat_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAITHI
  } rxState_t;

endpackage

// File: rtl/fmt_uart_fifo.sv
module fmt_uart_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) begin
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full) else $error("queue push while full"); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty) else $error("queue pop while empty"); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)) else $error("queue count out of range"); // R8

endmodule

// File: rtl/fmt_uart_dp.sv
module fmt_uart_dp
  import fmt_uart_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  frameCfg_t        cfg,
  input  logic [DIV_W-1:0] divisor,
  input  logic [7:0]       txWrData,
  input  logic             rxd,
  output logic             txd,
  output lineStat_t        stat,
  output logic [7:0]       headChar
);
  localparam int ENTRY_W = 10;
  localparam logic [3:0] SUB_LAST = 4'd15;
  localparam logic [3:0] SUB_MID  = 4'd7;
  localparam logic [3:0] TX_LAST_BIT = 4'd9;
  localparam logic [3:0] RX_LAST_BIT = 4'd7;

  // baud tick, sixteen per bit
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt >= divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // transmit path
  logic [7:0] holdReg;
  logic       holdFull;
  logic       txBusy;
  logic [8:0] txShift;
  logic [3:0] txBit, txSub;
  logic       txdR;
  logic       txLoad, txPar, txBit8;

  assign txLoad = holdFull && !txBusy;
  assign txPar  = (^holdReg[6:0]) ^ cfg.oddSense;
  assign txBit8 = cfg.parityMode ? txPar : holdReg[7];
  assign txd    = txdR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      txBusy   <= 1'b0;
      txShift  <= '1;
      txBit    <= '0;
      txSub    <= '0;
      txdR     <= 1'b1;
    end else begin
      if (strobe.loadTx && (!holdFull || txLoad)) begin
        holdReg  <= txWrData;
        holdFull <= 1'b1;
      end else if (txLoad) begin
        holdFull <= 1'b0;
      end
      if (txLoad) begin
        txBusy  <= 1'b1;
        txdR    <= 1'b0;
        txShift <= {1'b1, txBit8, holdReg[6:0]};
        txBit   <= '0;
        txSub   <= '0;
      end else if (txBusy && tick) begin
        if (txSub == SUB_LAST) begin
          txSub <= '0;
          if (txBit == TX_LAST_BIT) begin
            txBusy <= 1'b0;
            txdR   <= 1'b1;
          end else begin
            txdR    <= txShift[0];
            txShift <= {1'b1, txShift[8:1]};
            txBit   <= txBit + 1'b1;
          end
        end else begin
          txSub <= txSub + 1'b1;
        end
      end
    end
  end

  // receive path
  logic [1:0] rxSync;
  logic       rxS;
  rxState_t   rxState;
  logic [3:0] rxSub, rxBit;
  logic [7:0] rxShift;
  logic       overrun;
  logic       stopSample, ovrHit, rxPush, fifoFull, fifoEmpty;
  logic       rxPerr;
  logic [7:0] rxChar;
  logic [ENTRY_W-1:0] headEntry;

  assign rxS        = rxSync[1];
  assign stopSample = (rxState == RX_STOP) && tick && (rxSub == SUB_LAST);
  assign ovrHit     = stopSample && fifoFull;
  assign rxPush     = stopSample && !fifoFull;
  assign rxPerr     = cfg.parityMode && ((^rxShift) ^ cfg.oddSense);
  assign rxChar     = cfg.parityMode ? {1'b0, rxShift[6:0]} : rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      overrun <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (ovrHit)             overrun <= 1'b1;
      else if (strobe.clrOvr) overrun <= 1'b0;
      case (rxState)
        RX_IDLE: begin
          if (!rxS) begin
            rxState <= RX_START;
            rxSub   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxSub == SUB_MID) begin
              rxSub   <= '0;
              rxBit   <= '0;
              rxState <= rxS ? RX_IDLE : RX_DATA;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (rxSub == SUB_LAST) begin
              rxSub   <= '0;
              rxShift <= {rxS, rxShift[7:1]};
              if (rxBit == RX_LAST_BIT) rxState <= RX_STOP;
              else                      rxBit   <= rxBit + 1'b1;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (rxSub == SUB_LAST) begin
              rxSub   <= '0;
              rxState <= rxS ? RX_IDLE : RX_WAITHI;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
        end
        RX_WAITHI: begin
          if (rxS) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  fmt_uart_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_rxq (
    .clk      (clk),
    .rstN     (rstN),
    .push     (rxPush),
    .pushData ({rxPerr, !rxS, rxChar}),
    .pop      (strobe.popRx),
    .headData (headEntry),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  assign headChar       = fifoEmpty ? 8'h00 : headEntry[7:0];
  assign stat.rxAvail   = !fifoEmpty;
  assign stat.holdEmpty = !holdFull;
  assign stat.headFerr  = !fifoEmpty && headEntry[8];
  assign stat.headPerr  = !fifoEmpty && headEntry[9];
  assign stat.overrun   = overrun;
  assign stat.txIdle    = !txBusy;

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txdR) else $error("line not high while idle"); // R4
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txdR) else $error("frame did not open low"); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !strobe.clrOvr) |=> overrun) else $error("overrun lost"); // R9
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrOvr && !ovrHit) |=> !overrun) else $error("overrun not cleared"); // R9

endmodule

// File: rtl/fmt_uart_ctrl.sv
module fmt_uart_ctrl
  import fmt_uart_pkg::*;
#(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       addr,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             irq,
  output ctlStrobe_t       strobe,
  output frameCfg_t        cfg,
  output logic [DIV_W-1:0] divisor,
  input  lineStat_t        stat,
  input  logic [7:0]       headChar
);
  logic [3:0] ctrlReg;
  logic [7:0] statByte;

  assign cfg.parityMode = ctrlReg[0];
  assign cfg.oddSense   = ctrlReg[1];

  assign strobe.popRx  = rdEn && (addr == ADDR_DATA) && stat.rxAvail;
  assign strobe.loadTx = wrEn && (addr == ADDR_DATA);
  assign strobe.clrOvr = rdEn && (addr == ADDR_STAT);

  assign statByte = {2'b00, stat.txIdle, stat.overrun, stat.headPerr,
                     stat.headFerr, stat.holdEmpty, stat.rxAvail};

  assign irq = (ctrlReg[2] && stat.rxAvail) || (ctrlReg[3] && stat.holdEmpty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divisor <= DIV_RESET;
      rdData  <= '0;
    end else begin
      if (wrEn && addr == ADDR_CTRL) ctrlReg <= wrData[3:0];
      if (wrEn && addr == ADDR_DIV)  divisor <= DIV_W'(wrData);
      if (rdEn) begin
        case (addr)
          ADDR_DATA: rdData <= headChar;
          ADDR_STAT: rdData <= statByte;
          ADDR_CTRL: rdData <= {4'b0000, ctrlReg};
          default:   rdData <= 8'(divisor);
        endcase
      end
    end
  end

  AST_NO_POP_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_DATA && !stat.rxAvail) |=> (rdData == 8'h00))
    else $error("empty read returned data"); // R8

endmodule

// File: rtl/fmt_uart.sv
module fmt_uart
  import fmt_uart_pkg::*;
#(
  parameter int               DIV_W     = 8,
  parameter int               DEPTH     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  ctlStrobe_t       strobe;
  frameCfg_t        cfg;
  lineStat_t        stat;
  logic [DIV_W-1:0] divisor;
  logic [7:0]       headChar;

  fmt_uart_ctrl #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .irq      (irq),
    .strobe   (strobe),
    .cfg      (cfg),
    .divisor  (divisor),
    .stat     (stat),
    .headChar (headChar)
  );

  fmt_uart_dp #(.DIV_W(DIV_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfg      (cfg),
    .divisor  (divisor),
    .txWrData (wrData),
    .rxd      (rxd),
    .txd      (txd),
    .stat     (stat),
    .headChar (headChar)
  );

endmodule

// File: tb/fmt_uart_tb.sv
`timescale 1ns/1ps
module fmt_uart_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] addr = '0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic txd, irq;
  logic loopMode = 1'b0;
  logic rxLine = 1'b1;
  logic rxdIn;

  int checks = 0;
  int fails = 0;
  int curDiv = 0;
  bit done = 0;

  logic [7:0] expVal[$];
  string      expTag[$];
  event       gotChar;
  logic [7:0] gotVal;

  assign rxdIn = loopMode ? txd : rxLine;

  always #2.5 clk = ~clk;

  fmt_uart u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .rxd(rxdIn), .txd(txd), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every character read out against the queue
  initial forever begin
    @(gotChar);
    if (expVal.size() == 0) begin
      checks++; fails++;
      $display("FAIL R8 unexpected character actual=%0h expected=none", gotVal);
    end else begin
      automatic logic [7:0] e = expVal.pop_front();
      automatic string t = expTag.pop_front();
      check(gotVal == e, t, gotVal, e);
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic expectChar(input logic [7:0] v, input string tag);
    expVal.push_back(v); expTag.push_back(tag);
  endtask

  task automatic readChar();
    logic [7:0] d;
    busRead(2'd0, d);
    gotVal = d;
    -> gotChar;
    #0;
  endtask

  task automatic setDiv(input int dv);
    busWrite(2'd3, 8'(dv));
    curDiv = dv;
  endtask

  function automatic int bitClk();
    return 16 * (curDiv + 1);
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] payload, input logic stopBit);
    logic [9:0] f;
    f = {stopBit, payload, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxLine = f[i];
      waitClk(bitClk());
    end
    rxLine = 1'b1;
    waitClk(40);
  endtask

  task automatic captureTx(output logic [9:0] bits);
    while (txd) @(negedge clk);
    waitClk(bitClk() / 2);
    for (int i = 0; i < 10; i++) begin
      bits[i] = txd;
      if (i < 9) waitClk(bitClk());
    end
    waitClk(bitClk() + 40);
  endtask

  task automatic checkStatus(input logic [7:0] exp, input string tag);
    logic [7:0] s;
    busRead(2'd1, s);
    check(s == exp, tag, s, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [9:0] bits;
    int cnt;

    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // R1 reset state
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(rdData == 8'h00, "R1 rdData", rdData, 0);
    checkStatus(8'h22, "R1 status");

    // R2 register readback
    setDiv(1);
    busRead(2'd3, d); check(d == 8'h01, "R2 divisor readback", d, 1);
    busWrite(2'd2, 8'h0C);
    busRead(2'd2, d); check(d == 8'h0C, "R2 control readback", d, 8'h0C);

    // R12 interrupt sources
    busWrite(2'd2, 8'h08);
    waitClk(1); check(irq == 1'b1, "R12 tx empty irq", irq, 1);
    busWrite(2'd2, 8'h04);
    waitClk(1); check(irq == 1'b0, "R12 rx irq with empty queue", irq, 0);
    busWrite(2'd2, 8'h00);

    // R8 empty read
    busRead(2'd0, d); check(d == 8'h00, "R8 empty read value", d, 0);
    checkStatus(8'h22, "R8 empty read no effect");

    // R4 eight-bit loopback
    loopMode = 1'b1;
    busWrite(2'd0, 8'hA5);
    captureTx(bits);
    check(bits == {1'b1, 8'hA5, 1'b0}, "R4 tx frame 8N1", bits, {1'b1, 8'hA5, 1'b0});
    checkStatus(8'h23, "R4 status after rx");
    expectChar(8'hA5, "R4 loopback char");
    readChar();

    // R11 holding register overwrite protection
    busWrite(2'd0, 8'h11);
    busWrite(2'd0, 8'h22);
    busWrite(2'd0, 8'h33);
    busRead(2'd1, d); check(d[1] == 1'b0, "R11 holding full", d[1], 0);
    waitClk(3 * 10 * bitClk() + 100);
    expectChar(8'h11, "R11 first char");
    expectChar(8'h22, "R11 second char");
    readChar(); readChar();
    checkStatus(8'h22, "R11 third write dropped");

    // R3 bit period with divisor 3
    setDiv(3);
    busWrite(2'd0, 8'h55);
    while (txd) @(negedge clk);
    while (!txd) @(negedge clk);
    cnt = 0;
    while (txd) begin @(negedge clk); cnt++; end
    check(cnt == 64, "R3 bit period", cnt, 64);
    waitClk(10 * bitClk());
    expectChar(8'h55, "R3 char at divisor 3");
    readChar();
    setDiv(1);

    // R5 parity transmit, even then odd
    busWrite(2'd2, 8'h01);
    busWrite(2'd0, 8'hC3);
    captureTx(bits);
    check(bits == {1'b1, 1'b1, 7'h43, 1'b0}, "R5 even parity frame", bits, {1'b1, 1'b1, 7'h43, 1'b0});
    checkStatus(8'h23, "R6 no parity error on good char");
    expectChar(8'h43, "R5 bit7 cleared");
    readChar();
    busWrite(2'd2, 8'h03);
    busWrite(2'd0, 8'h43);
    captureTx(bits);
    check(bits == {1'b1, 1'b0, 7'h43, 1'b0}, "R5 odd parity frame", bits, {1'b1, 1'b0, 7'h43, 1'b0});
    expectChar(8'h43, "R5 odd loopback char");
    readChar();

    // R6 parity error detection (even sense)
    loopMode = 1'b0;
    busWrite(2'd2, 8'h01);
    sendFrame({1'b0, 7'h43}, 1'b1);
    sendFrame({1'b1, 7'h43}, 1'b1);
    checkStatus(8'h2B, "R6 parity error flagged");
    expectChar(8'h43, "R6 bad char data");
    readChar();
    checkStatus(8'h23, "R6 good char no flag");
    expectChar(8'h43, "R6 good char data");
    readChar();

    // R7 framing error and recovery
    busWrite(2'd2, 8'h00);
    sendFrame(8'h5A, 1'b0);
    checkStatus(8'h27, "R7 framing error flagged");
    expectChar(8'h5A, "R7 bad stop char");
    readChar();
    sendFrame(8'h99, 1'b1);
    expectChar(8'h99, "R7 recovery char");
    readChar();

    // R10 short glitch
    rxLine = 1'b0; waitClk(4); rxLine = 1'b1;
    waitClk(10 * bitClk());
    checkStatus(8'h22, "R10 glitch ignored");

    // R9 overrun
    for (int i = 0; i < 9; i++) sendFrame(8'(8'h10 + i), 1'b1);
    checkStatus(8'h33, "R9 overrun set");
    checkStatus(8'h23, "R9 overrun cleared by read");
    for (int i = 0; i < 8; i++) begin
      expectChar(8'(8'h10 + i), "R8 queue order");
      readChar();
    end
    checkStatus(8'h22, "R9 ninth char dropped");

    // R12 receive interrupt
    busWrite(2'd2, 8'h04);
    sendFrame(8'h7E, 1'b1);
    check(irq == 1'b1, "R12 rx irq", irq, 1);
    expectChar(8'h7E, "R12 char");
    readChar();
    waitClk(1);
    check(irq == 1'b0, "R12 irq drops after pop", irq, 0);

    check(expVal.size() == 0, "R8 scoreboard drained", expVal.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule